// File: doc/BRIEF.md
# Zero-Overhead Block Loop Sequencer

This block sits beside the fetch stage of a simple in-order core and runs hardware block loops. When a loop-start command arrives, it loads a 13-bit iteration counter and a 16-bit last-address register. It sets the active-loop flag and moves the flag's previous value into an outer-loop flag. It also pushes the address of the first body instruction onto a two-entry return stack. That address is the start instruction's address plus two, because the start instruction is two words long.

From then on the block compares every fetch address with the last-address register. On a match it picks the next fetch address combinationally, in the same cycle, so looping costs no cycles. If the counter is not one, fetch goes back to the body top. The body top is read from the stack without removing it, and the counter decrements. If the counter is one, fetch falls through to the next address, the stack entry is dropped, and the flags shift back.

The start command is a valid/ready input. `cmd_ready` is always high, so the command source never sees back-pressure. Every command presented with `cmd_valid` is consumed in that cycle. An illegal command (an immediate count of zero, or a third nested loop) is discarded with a one-cycle error pulse and changes no state. Fetch and status pins are plain signals.

Top module: `loop_seq`

## Requirements
- R1: After reset the counter, last-address register, both flags and stack depth are zero, all error pulses are low, and `cmd_ready` is high.
- R2: An accepted start command updates the state at the next clock edge. The counter takes the count, and the last-address register takes `cmd_last_addr`. The active flag becomes 1, the outer flag takes the old active flag, and the stack depth rises by one. The count source is selected by `cmd_from_reg`: 0 means the 6-bit immediate, zero-extended; 1 means the 13-bit register value.
- R3: A register count is loaded as given, over all 13 bits (for example 13'h1005 loads 4101).
- R4: The pushed return address is `cmd_pc + 2`. It is the address that `fetch_next` shows on every redirect of that loop.
- R5: A valid fetch that equals the last address, while the active flag is 1 and the counter is not 1, drives `fetch_next` to the stack top with `fetch_redirect` = 1 in the same cycle. The counter then decrements at the edge and the stack depth is unchanged.
- R6: The same match with the counter equal to 1 drives `fetch_next` = `fetch_addr + 1` with `fetch_redirect` = 0. At the edge the stack depth drops by one, the active flag takes the outer flag, and the outer flag clears.
- R7: A fetch that does not match, or any fetch while the active flag is 0, gives `fetch_addr + 1` with no redirect and leaves the counter and the depth unchanged.
- R8: A register count of zero makes the body run 8192 times: the block redirects 8191 times before it falls through.
- R9: A start with `cmd_from_reg` = 0 and an immediate of zero raises `err_zero_count` for exactly the cycle after the command, and changes no loop state.
- R10: A start while the stack holds two entries raises `err_stack_full` for one cycle, and the state stays as it was.
- R11: `err_stack_empty` flags a pop from an empty stack. The start and end rules keep this from happening, even after rejected commands.
- R12: When a start command and a matching fetch arrive in the same cycle, the start takes effect and the loop-end check is skipped for that fetch (`fetch_next` = `fetch_addr + 1`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Loop-start command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_from_reg | input | 1 | 1: count from register value, 0: from immediate |
| cmd_imm | input | 6 | Immediate count |
| cmd_reg | input | 13 | Register count (low bits of a core register) |
| cmd_last_addr | input | 16 | Address of the last body instruction |
| cmd_pc | input | 16 | Address of the loop-start instruction |
| fetch_valid | input | 1 | Fetch address valid this cycle |
| fetch_addr | input | 16 | Current fetch address |
| fetch_next | output | 16 | Next fetch address |
| fetch_redirect | output | 1 | Next address is the loop top |
| loop_count | output | 13 | Iteration counter |
| loop_last | output | 16 | Last-address register |
| loop_active | output | 1 | Active-loop flag |
| loop_outer | output | 1 | Outer-loop (previous flag) bit |
| stack_depth | output | 2 | Return-stack entries in use |
| err_zero_count | output | 1 | Zero immediate count rejected (pulse) |
| err_stack_full | output | 1 | Start rejected, stack full (pulse) |
| err_stack_empty | output | 1 | Pop from empty stack (pulse) |

## Verification
Loops are driven with small immediate counts and with register counts that use the top counter bit. This separates a correct 13-bit load from a truncated or immediate-only path. Repeated fetches of the last address count the redirects, so an off-by-one at the counter-equals-one exit is caught. A zero register count shows the 8192-pass wrap. In-body and inactive-flag fetches show that only a true end match redirects. Nested starts, a third rejected start and a start that collides with a loop-end fetch check the flag chain, the stack bound and the priority rule.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;
  localparam int unsigned ADDR_W_D = 16;
  localparam int unsigned LC_W_D   = 13;
  localparam int unsigned IMM_W_D  = 6;
  localparam int unsigned DEPTH_D  = 2;
  localparam int unsigned BODY_D   = 2;

  typedef enum logic [1:0] {
    ACT_STEP   = 2'd0,
    ACT_REPEAT = 2'd1,
    ACT_EXIT   = 2'd2
  } fetch_act_e;
endpackage

// File: rtl/loop_stack.sv
module loop_stack #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [W-1:0]     push_data,
  input  logic             pop_req,
  output logic [W-1:0]     top,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             overflow,
  output logic             underflow
);
  logic [W-1:0] ent [DEPTH];
  logic         push_ok, pop_ok;

  assign full      = (count == CNT_W'(DEPTH));
  assign push_ok   = push_req && !full;
  assign pop_ok    = pop_req && (count != '0);
  assign overflow  = push_req && full;
  assign underflow = pop_req && (count == '0);

  for (genvar i = 0; i < int'(DEPTH); i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent[i] <= '0;
      else if (push_ok && count == CNT_W'(i))
        ent[i] <= push_data;
    end
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < int'(DEPTH); i++)
      if (count == CNT_W'(i + 1)) top = ent[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (push_ok) count <= count + CNT_W'(1);
    else if (pop_ok)  count <= count - CNT_W'(1);
  end
endmodule

// File: rtl/loop_ctrl.sv
module loop_ctrl
  import loop_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LC_W   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LC_W-1:0]   load_count,
  input  logic [ADDR_W-1:0] load_last,
  input  logic              hold_end,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [ADDR_W-1:0] stack_top,
  output fetch_act_e        act,
  output logic [ADDR_W-1:0] next_pc,
  output logic [LC_W-1:0]   count,
  output logic [ADDR_W-1:0] last,
  output logic              active,
  output logic              outer
);
  logic at_end;

  assign at_end = fetch_valid && active && !hold_end && (fetch_addr == last);

  always_comb begin
    act     = ACT_STEP;
    next_pc = fetch_addr + ADDR_W'(1);
    if (at_end) begin
      if (count != LC_W'(1)) begin
        act     = ACT_REPEAT;
        next_pc = stack_top;
      end else begin
        act = ACT_EXIT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      last   <= '0;
      active <= 1'b0;
      outer  <= 1'b0;
    end else if (load) begin
      count  <= load_count;
      last   <= load_last;
      active <= 1'b1;
      outer  <= active;
    end else if (act == ACT_REPEAT) begin
      count <= count - LC_W'(1);
    end else if (act == ACT_EXIT) begin
      active <= outer;
      outer  <= 1'b0;
    end
  end
endmodule

// File: rtl/loop_seq.sv
module loop_seq
  import loop_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_D,
  parameter int unsigned LC_W   = LC_W_D,
  parameter int unsigned IMM_W  = IMM_W_D,
  parameter int unsigned DEPTH  = DEPTH_D,
  parameter int unsigned BODY   = BODY_D,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_from_reg,
  input  logic [IMM_W-1:0]  cmd_imm,
  input  logic [LC_W-1:0]   cmd_reg,
  input  logic [ADDR_W-1:0] cmd_last_addr,
  input  logic [ADDR_W-1:0] cmd_pc,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] fetch_next,
  output logic              fetch_redirect,
  output logic [LC_W-1:0]   loop_count,
  output logic [ADDR_W-1:0] loop_last,
  output logic              loop_active,
  output logic              loop_outer,
  output logic [CNT_W-1:0]  stack_depth,
  output logic              err_zero_count,
  output logic              err_stack_full,
  output logic              err_stack_empty
);
  logic              fire, zero_imm, legal, load;
  logic              full, ovf, unf;
  logic [LC_W-1:0]   count_sel;
  logic [ADDR_W-1:0] top;
  fetch_act_e        act;

  assign cmd_ready = 1'b1;
  assign fire      = cmd_valid && cmd_ready;
  assign zero_imm  = fire && !cmd_from_reg && (cmd_imm == '0);
  assign legal     = fire && !zero_imm;
  assign load      = legal && !full;
  assign count_sel = cmd_from_reg ? cmd_reg : LC_W'(cmd_imm);

  loop_stack #(.W(ADDR_W), .DEPTH(DEPTH)) i_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (legal),
    .push_data (cmd_pc + ADDR_W'(BODY)),
    .pop_req   (act == ACT_EXIT),
    .top       (top),
    .count     (stack_depth),
    .full      (full),
    .overflow  (ovf),
    .underflow (unf)
  );

  loop_ctrl #(.ADDR_W(ADDR_W), .LC_W(LC_W)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .load_count  (count_sel),
    .load_last   (cmd_last_addr),
    .hold_end    (fire),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .stack_top   (top),
    .act         (act),
    .next_pc     (fetch_next),
    .count       (loop_count),
    .last        (loop_last),
    .active      (loop_active),
    .outer       (loop_outer)
  );

  assign fetch_redirect = (act == ACT_REPEAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_zero_count  <= 1'b0;
      err_stack_full  <= 1'b0;
      err_stack_empty <= 1'b0;
    end else begin
      err_zero_count  <= zero_imm;
      err_stack_full  <= ovf;
      err_stack_empty <= unf;
    end
  end
endmodule

// File: rtl/loop_seq_chk.sv
module loop_seq_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LC_W   = 13,
  parameter int unsigned IMM_W  = 6,
  parameter int unsigned DEPTH  = 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_from_reg,
  input logic [IMM_W-1:0]  cmd_imm,
  input logic [ADDR_W-1:0] cmd_last_addr,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              fetch_redirect,
  input logic [LC_W-1:0]   loop_count,
  input logic [ADDR_W-1:0] loop_last,
  input logic              loop_active,
  input logic              loop_outer,
  input logic [CNT_W-1:0]  stack_depth,
  input logic              err_zero_count,
  input logic              err_stack_empty
);
  // R2: legal start loads state and shifts the flag chain
  a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_from_reg || cmd_imm != '0) && stack_depth < CNT_W'(DEPTH)
    |=> loop_active && loop_outer == $past(loop_active) && loop_last == $past(cmd_last_addr));

  // R5: a redirect decrements the counter and keeps the stack entry
  a_r5_peek_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_redirect |=> loop_count == LC_W'($past(loop_count) - LC_W'(1)) && $stable(stack_depth));

  // R6: the final pass pops and restores the flags
  a_r6_exit_pop: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !cmd_valid && loop_active && fetch_addr == loop_last && loop_count == LC_W'(1)
    |=> stack_depth == CNT_W'($past(stack_depth) - CNT_W'(1)) && loop_active == $past(loop_outer) && !loop_outer);

  // R9: zero immediate is flagged and leaves the depth alone
  a_r9_zero_imm: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_from_reg && cmd_imm == '0 |=> err_zero_count && $stable(stack_depth));

  // R10: the stack never exceeds its depth
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    stack_depth <= CNT_W'(DEPTH));

  // R11: no pop from an empty stack
  a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    !err_stack_empty);
endmodule

bind loop_seq loop_seq_chk #(.ADDR_W(ADDR_W), .LC_W(LC_W), .IMM_W(IMM_W), .DEPTH(DEPTH)) i_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmd_valid       (cmd_valid),
  .cmd_from_reg    (cmd_from_reg),
  .cmd_imm         (cmd_imm),
  .cmd_last_addr   (cmd_last_addr),
  .fetch_valid     (fetch_valid),
  .fetch_addr      (fetch_addr),
  .fetch_redirect  (fetch_redirect),
  .loop_count      (loop_count),
  .loop_last       (loop_last),
  .loop_active     (loop_active),
  .loop_outer      (loop_outer),
  .stack_depth     (stack_depth),
  .err_zero_count  (err_zero_count),
  .err_stack_empty (err_stack_empty)
);

// File: tb/test_loop_seq.sv
module test_loop_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_from_reg = 1'b0;
  logic [5:0]  cmd_imm = '0;
  logic [12:0] cmd_reg = '0;
  logic [15:0] cmd_last_addr = '0, cmd_pc = '0;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        cmd_ready, fetch_redirect, loop_active, loop_outer;
  logic [15:0] fetch_next, loop_last;
  logic [12:0] loop_count;
  logic [1:0]  stack_depth;
  logic        err_zero_count, err_stack_full, err_stack_empty;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_seq i_loop_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_from_reg(cmd_from_reg), .cmd_imm(cmd_imm), .cmd_reg(cmd_reg),
    .cmd_last_addr(cmd_last_addr), .cmd_pc(cmd_pc), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .fetch_next(fetch_next), .fetch_redirect(fetch_redirect),
    .loop_count(loop_count), .loop_last(loop_last), .loop_active(loop_active),
    .loop_outer(loop_outer), .stack_depth(stack_depth), .err_zero_count(err_zero_count),
    .err_stack_full(err_stack_full), .err_stack_empty(err_stack_empty)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_valid = 1'b0; fetch_valid = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0; fetch_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic drive_cmd(input logic from_reg, input logic [5:0] imm, input logic [12:0] rv,
                           input logic [15:0] last, input logic [15:0] pc);
    cmd_valid = 1'b1; cmd_from_reg = from_reg; cmd_imm = imm; cmd_reg = rv;
    cmd_last_addr = last; cmd_pc = pc;
  endtask

  task automatic start(input logic from_reg, input logic [5:0] imm, input logic [12:0] rv,
                       input logic [15:0] last, input logic [15:0] pc);
    @(negedge clk);
    fetch_valid = 1'b0;
    drive_cmd(from_reg, imm, rv, last, pc);
    idle();
  endtask

  task automatic fetch(input logic [15:0] a);
    @(negedge clk);
    cmd_valid = 1'b0; fetch_valid = 1'b1; fetch_addr = a;
    #1;
  endtask

  task automatic run_loop(input logic [15:0] a, input int limit, output int redirs,
                          output logic [15:0] exit_next);
    redirs = 0;
    exit_next = '0;
    for (int i = 0; i < limit; i++) begin
      fetch(a);
      if (fetch_redirect) redirs++;
      else begin exit_next = fetch_next; break; end
    end
    idle();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 count", loop_count, 0);
    check("R1 last", loop_last, 0);
    check("R1 flags", {loop_active, loop_outer}, 0);
    check("R1 depth", stack_depth, 0);
    check("R1 errors", {err_zero_count, err_stack_full, err_stack_empty}, 0);
    check("R1 ready", cmd_ready, 1);
  endtask

  task automatic t_imm_loop();
    int r; logic [15:0] nx;
    do_reset();
    start(1'b0, 6'd3, 13'h1FFF, 16'd105, 16'd100);
    check("R2 count", loop_count, 3);
    check("R2 last", loop_last, 105);
    check("R2 flags", {loop_active, loop_outer}, 2'b10);
    check("R2 depth", stack_depth, 1);
    fetch(16'd103);
    check("R7 in-body next", fetch_next, 104);
    check("R7 in-body redirect", fetch_redirect, 0);
    fetch(16'd105);
    check("R4 top addr", fetch_next, 102);
    check("R5 redirect", fetch_redirect, 1);
    idle();
    check("R5 count dec", loop_count, 2);
    check("R5 depth kept", stack_depth, 1);
    run_loop(16'd105, 10, r, nx);
    check("R6 redirects left", r, 1);
    check("R6 exit next", nx, 106);
    check("R6 depth", stack_depth, 0);
    check("R6 flags", {loop_active, loop_outer}, 0);
    fetch(16'd105);
    check("R7 inactive next", fetch_next, 106);
    check("R7 inactive redirect", fetch_redirect, 0);
    idle();
    check("R7 count held", loop_count, 1);
  endtask

  task automatic t_reg_count();
    int r; logic [15:0] nx;
    do_reset();
    start(1'b1, 6'd0, 13'h1005, 16'h8010, 16'h8000);
    check("R3 reg count", loop_count, 13'h1005);
    do_reset();
    start(1'b1, 6'd9, 13'd4, 16'h0050, 16'h0040);
    check("R3 reg over imm", loop_count, 4);
    run_loop(16'h0050, 10, r, nx);
    check("R3 reg loop redirects", r, 3);
  endtask

  task automatic t_zero_reg();
    int r; logic [15:0] nx;
    do_reset();
    start(1'b1, 6'd5, 13'd0, 16'd20, 16'd10);
    check("R8 count loaded", loop_count, 0);
    run_loop(16'd20, 9000, r, nx);
    check("R8 redirects", r, 8191);
    check("R8 exit next", nx, 21);
  endtask

  task automatic t_zero_imm();
    do_reset();
    start(1'b0, 6'd0, 13'd7, 16'd55, 16'd50);
    check("R9 pulse", err_zero_count, 1);
    check("R9 flags", {loop_active, loop_outer}, 0);
    check("R9 depth", stack_depth, 0);
    check("R9 last", loop_last, 0);
    idle();
    check("R9 pulse ends", err_zero_count, 0);
  endtask

  task automatic t_nested();
    do_reset();
    start(1'b0, 6'd4, 13'd0, 16'd200, 16'd190);
    start(1'b0, 6'd2, 13'd0, 16'd150, 16'd140);
    check("R2 nested flags", {loop_active, loop_outer}, 2'b11);
    check("R2 nested depth", stack_depth, 2);
    start(1'b0, 6'd5, 13'd0, 16'd170, 16'd160);
    check("R10 pulse", err_stack_full, 1);
    check("R10 count kept", loop_count, 2);
    check("R10 last kept", loop_last, 150);
    check("R10 depth kept", stack_depth, 2);
    idle();
    check("R10 pulse ends", err_stack_full, 0);
    fetch(16'd150);
    check("R4 inner top", fetch_next, 142);
    fetch(16'd150);
    check("R6 inner exit next", fetch_next, 151);
    idle();
    check("R6 inner exit depth", stack_depth, 1);
    check("R6 inner exit flags", {loop_active, loop_outer}, 2'b10);
    fetch(16'd150);
    idle();
    check("R11 second exit depth", stack_depth, 0);
    check("R11 no underflow", err_stack_empty, 0);
    fetch(16'd150);
    idle();
    check("R11 still no underflow", err_stack_empty, 0);
  endtask

  task automatic t_collide();
    do_reset();
    start(1'b0, 6'd2, 13'd0, 16'd300, 16'd290);
    @(negedge clk);
    drive_cmd(1'b0, 6'd7, 13'd0, 16'd400, 16'd390);
    fetch_valid = 1'b1; fetch_addr = 16'd300;
    #1;
    check("R12 next", fetch_next, 301);
    check("R12 redirect", fetch_redirect, 0);
    idle();
    check("R12 count", loop_count, 7);
    check("R12 last", loop_last, 400);
    check("R12 depth", stack_depth, 2);
    check("R12 flags", {loop_active, loop_outer}, 2'b11);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_imm_loop();
    t_reg_count();
    t_zero_reg();
    t_zero_imm();
    t_nested();
    t_collide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule